// File: doc/BRIEF.md
# Sequential Cubic Polynomial Evaluator

This block evaluates a third-degree polynomial in fixed point by nested multiply-add: starting from the leading coefficient, it multiplies the running value by the argument, truncates, and adds the next coefficient. This is done three times. One multiplier and one adder are shared across all three steps. The argument is an unsigned 18-bit fraction in the range [0, 1). Coefficients are two's complement values with 28 fractional bits. Every intermediate value carries 30 fractional bits.

A caller pulses `start_i`, presenting the argument on `x_i` and the leading coefficient on `coef_i` in that same cycle. The block then asks for the remaining coefficients one at a time on `coef_req_o`/`coef_idx_o`. The coefficient source must drive the requested value on `coef_i` in the cycle of the request, for example from a table addressed combinationally. When the result is ready the block raises `done_o` for one cycle, and the 35-bit result on `result_o` stays stable until the next completion.

Controller states:
- `ST_IDLE` waits for start.
- `ST_MUL` forms the truncated product.
- `ST_ADD` requests a coefficient and adds it.
- `ST_DONE` presents the result.

Transitions:
- start: `ST_IDLE` to `ST_MUL`.
- product taken: `ST_MUL` to `ST_ADD`.
- more coefficients: `ST_ADD` to `ST_MUL`.
- last coefficient: `ST_ADD` to `ST_DONE`.
- result shown: `ST_DONE` to `ST_IDLE`.

Top module: `hcub_eval`

## Requirements
- R1: While `rst_n` is low and after its release, `busy_o`, `done_o` and `coef_req_o` are 0 and `result_o` is 0.
- R2: A high `start_i` in the idle state samples `x_i` as the argument and `coef_i` as the leading coefficient (28 fractional bits), and `busy_o` is 1 from the next cycle.
- R3: After the edge that accepts start (edge E0), `coef_req_o` is high for one cycle after E1, E3 and E5. `coef_idx_o` is 2 (second coefficient), 1 (third) and 0 (constant term) respectively. Each value on `coef_i` is taken at the following edge.
- R4: Each product of the running value (30 fractional bits) and the argument (18 fractional bits) is truncated toward negative infinity to 30 fractional bits, that is, its low 18 bits are dropped.
- R5: Each coefficient is sign-extended and shifted left by two bit positions before it is added, so that its 28 fractional bits line up with the 30 of the product. The leading coefficient is aligned the same way when it is loaded.
- R6: The sum after the second, third and constant-term additions is wrapped in two's complement to 58, 45 and 35 bits respectively.
- R7: `done_o` is high for exactly one cycle, after E6 (a latency of 7 cycles from the start cycle). `result_o` then holds the 35-bit final sum (30 fractional bits) and does not change until the next `done_o`.
- R8: `start_i` is ignored while `busy_o` is 1, including the cycle in which `done_o` is high. It changes neither the result, the timing nor the coefficient order.
- R9: `busy_o` returns to 0 after E7, and a start in that idle cycle is accepted.
- R10: `coef_i` is ignored in every cycle other than the start cycle and the cycles with `coef_req_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an evaluation (taken only when idle) |
| x_i | input | 18 | Unsigned argument, all bits fractional |
| coef_i | input | 67 | Signed coefficient, 28 fractional bits |
| coef_req_o | output | 1 | Coefficient wanted this cycle |
| coef_idx_o | output | 2 | Which coefficient: 2, 1 or 0 |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | 35 | Signed result, 30 fractional bits |

## Verification
The bench builds the evaluator with its default formats: an 18-bit argument, a 67-bit leading coefficient, a 69-bit running value and step widths of 58, 45 and 35 bits. At these sizes a leading coefficient near 2^60 drives the first sum past its 58-bit wrap point. Single-LSB arguments and coefficients expose the floor-versus-toward-zero truncation difference in a result that can be checked by hand. Start pulses placed inside a running evaluation and in its completion cycle exercise the busy-time rejection against the exact seven-cycle schedule.

// File: rtl/hcub_pkg.sv
package hcub_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_ADD  = 2'd2,
        ST_DONE = 2'd3
    } hcub_state_t;

    localparam logic [1:0] IDX_C2 = 2'd2;
    localparam logic [1:0] IDX_C1 = 2'd1;
    localparam logic [1:0] IDX_C0 = 2'd0;
endpackage

// File: rtl/hcub_ctrl.sv
module hcub_ctrl
    import hcub_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output logic       ld_o,
    output logic       mul_en_o,
    output logic       add_en_o,
    output logic       fin_en_o,
    output logic [1:0] step_o,
    output logic       coef_req_o,
    output logic [1:0] coef_idx_o,
    output logic       busy_o,
    output logic       done_o
);
    hcub_state_t state_q, state_d;
    logic [1:0]  step_q, step_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= IDX_C2;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                state_d = ST_MUL;
                step_d  = IDX_C2;
            end
            ST_MUL:  state_d = ST_ADD;
            ST_ADD: begin
                if (step_q == IDX_C0) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_MUL;
                    step_d  = step_q - 2'd1;
                end
            end
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ld_o       = (state_q == ST_IDLE) && start_i;
        mul_en_o   = (state_q == ST_MUL);
        add_en_o   = (state_q == ST_ADD);
        fin_en_o   = (state_q == ST_ADD) && (step_q == IDX_C0);
        step_o     = step_q;
        coef_req_o = (state_q == ST_ADD);
        coef_idx_o = step_q;
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_DONE);
    end

    // R7: completion strobe lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: third coefficient follows second, constant term follows third
    p_req_order_c1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_req_o && coef_idx_o == IDX_C1) |->
            ($past(coef_req_o, 2) && $past(coef_idx_o, 2) == IDX_C2));
    p_req_order_c0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_req_o && coef_idx_o == IDX_C0) |->
            ($past(coef_req_o, 2) && $past(coef_idx_o, 2) == IDX_C1));

    // R8: start during a multiply cycle does not disturb the schedule
    p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_en_o && start_i) |=> (add_en_o && $stable(step_q)));

    // R9: idle right after the completion cycle
    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

// File: rtl/hcub_datapath.sv
module hcub_datapath #(
    parameter int X_W    = 18,
    parameter int CF_W   = 67,
    parameter int CF_FR  = 28,
    parameter int ACC_FR = 30,
    parameter int S1_W   = 58,
    parameter int S2_W   = 45,
    parameter int RES_W  = 35
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_i,
    input  logic                    mul_en_i,
    input  logic                    add_en_i,
    input  logic                    fin_en_i,
    input  logic [1:0]              step_i,
    input  logic [X_W-1:0]          x_i,
    input  logic signed [CF_W-1:0]  coef_i,
    output logic signed [RES_W-1:0] result_o
);
    localparam int ALIGN  = ACC_FR - CF_FR;
    localparam int ACC_W  = CF_W + ALIGN;
    localparam int PROD_W = ACC_W + X_W;

    logic [X_W-1:0]          x_q;
    logic signed [ACC_W-1:0] acc_q, prod_q, coef_al, sum_raw, sum_wrap;
    logic signed [PROD_W-1:0] mul;
    logic                    unused_mul_lsb;
    logic signed [RES_W-1:0] res_q;
    int                      keep_w;

    function automatic logic signed [ACC_W-1:0] wrap_to(
        input logic signed [ACC_W-1:0] v, input int w);
        logic signed [ACC_W-1:0] t;
        t = v <<< (ACC_W - w);
        return t >>> (ACC_W - w);
    endfunction

    // product of running value and argument, floor-truncated by bit selection
    assign mul            = acc_q * $signed({1'b0, x_q});
    assign unused_mul_lsb = ^mul[X_W-1:0];

    // coefficient alignment from CF_FR to ACC_FR fractional bits
    assign coef_al = {coef_i, {ALIGN{1'b0}}};
    assign sum_raw = prod_q + coef_al;

    always_comb begin
        unique case (step_i)
            2'd2:    keep_w = S1_W;
            2'd1:    keep_w = S2_W;
            default: keep_w = RES_W;
        endcase
        sum_wrap = wrap_to(sum_raw, keep_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            acc_q  <= '0;
            prod_q <= '0;
            res_q  <= '0;
        end else begin
            if (ld_i) begin
                x_q   <= x_i;
                acc_q <= coef_al;
            end
            if (mul_en_i) prod_q <= mul[X_W +: ACC_W];
            if (add_en_i) acc_q  <= sum_wrap;
            if (fin_en_i) res_q  <= sum_wrap[RES_W-1:0];
        end
    end

    assign result_o = res_q;

    // R4: product magnitude never exceeds the running value, sign preserved
    p_prod_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_en_i && !acc_q[ACC_W-1]) |=>
            (!prod_q[ACC_W-1] && prod_q <= $past(acc_q)));
    p_prod_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_en_i && acc_q[ACC_W-1]) |=>
            (prod_q <= 0 && prod_q >= $past(acc_q)));
endmodule

// File: rtl/hcub_eval.sv
module hcub_eval #(
    parameter int X_W    = 18,
    parameter int CF_W   = 67,
    parameter int CF_FR  = 28,
    parameter int ACC_FR = 30,
    parameter int S1_W   = 58,
    parameter int S2_W   = 45,
    parameter int RES_W  = 35
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [X_W-1:0]          x_i,
    input  logic signed [CF_W-1:0]  coef_i,
    output logic                    coef_req_o,
    output logic [1:0]              coef_idx_o,
    output logic                    busy_o,
    output logic                    done_o,
    output logic signed [RES_W-1:0] result_o
);
    logic       ld, mul_en, add_en, fin_en;
    logic [1:0] step;

    hcub_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ld_o       (ld),
        .mul_en_o   (mul_en),
        .add_en_o   (add_en),
        .fin_en_o   (fin_en),
        .step_o     (step),
        .coef_req_o (coef_req_o),
        .coef_idx_o (coef_idx_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    hcub_datapath #(
        .X_W(X_W), .CF_W(CF_W), .CF_FR(CF_FR), .ACC_FR(ACC_FR),
        .S1_W(S1_W), .S2_W(S2_W), .RES_W(RES_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (ld),
        .mul_en_i (mul_en),
        .add_en_i (add_en),
        .fin_en_i (fin_en),
        .step_i   (step),
        .x_i      (x_i),
        .coef_i   (coef_i),
        .result_o (result_o)
    );

    // R7: result moves only together with the completion strobe
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done_o) |-> $stable(result_o));
endmodule

// File: tb/hcub_eval_tb.sv
`timescale 1ns/1ps
module hcub_eval_tb;
    localparam int NV = 6;
    localparam logic signed [66:0] JUNK = 67'sh5A5A5A5A5A5A5A5A5;
    localparam logic signed [66:0] ALT  = -67'sd987654321;

    localparam logic [17:0] TX[NV] = '{18'h3FFFF, 18'h20000, 18'h00000,
                                       18'h00001, 18'h3FFFF, 18'h12345};
    localparam logic signed [66:0] TA3[NV] = '{
        67'sd268435456, -67'sd3000000007, 67'sd777777777777,
        -67'sd1, 67'sh01000000000000000, -67'sd1125899906842624};
    localparam logic signed [66:0] TA2[NV] = '{
        -67'sd134217728, 67'sd123456789012, -67'sd5, -67'sd1,
        67'sd1000, 67'sd35184372088832};
    localparam logic signed [66:0] TA1[NV] = '{
        67'sd805306368, -67'sd98765432, 67'sd9, -67'sd1,
        -67'sd77, -67'sd8589934592};
    localparam logic signed [66:0] TA0[NV] = '{
        -67'sd1, 67'sd5, 67'sd1234567, -67'sd1,
        67'sd3, 67'sd2147483648};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [17:0] x_i = '0;
    logic signed [66:0] coef_i;
    logic coef_req_o, busy_o, done_o;
    logic [1:0] coef_idx_o;
    logic signed [34:0] result_o;

    logic signed [66:0] cur_a3, cur_a2, cur_a1, cur_a0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign coef_i = coef_req_o ? ((coef_idx_o == 2'd2) ? cur_a2 :
                                  (coef_idx_o == 2'd1) ? cur_a1 : cur_a0)
                  : (start_i ? (busy_o ? ALT : cur_a3) : JUNK);

    hcub_eval u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .x_i(x_i),
        .coef_i(coef_i), .coef_req_o(coef_req_o), .coef_idx_o(coef_idx_o),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    function automatic logic signed [127:0] wrapw(input logic signed [127:0] v, input int w);
        logic signed [127:0] t;
        t = v <<< (128 - w);
        return t >>> (128 - w);
    endfunction

    // independent model of R4, R5, R6
    function automatic logic [34:0] model(input logic [17:0] x,
        input logic signed [66:0] a3, input logic signed [66:0] a2,
        input logic signed [66:0] a1, input logic signed [66:0] a0);
        logic signed [127:0] v, xx, w3, w2, w1, w0;
        w3 = a3; w2 = a2; w1 = a1; w0 = a0;
        xx = {110'd0, x};
        v = w3 * 4;
        v = wrapw(((v * xx) >>> 18) + w2 * 4, 58);
        v = wrapw(((v * xx) >>> 18) + w1 * 4, 45);
        v = wrapw(((v * xx) >>> 18) + w0 * 4, 35);
        return v[34:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic run(input logic [17:0] x, input logic signed [66:0] a3,
        input logic signed [66:0] a2, input logic signed [66:0] a1,
        input logic signed [66:0] a0, input logic [34:0] exp, input bit inject);
        int cyc;
        int nreq;
        bit order_ok;
        cur_a3 = a3; cur_a2 = a2; cur_a1 = a1; cur_a0 = a0;
        x_i = x;
        start_i = 1'b1;
        @(negedge clk);
        cyc = 1; nreq = 0; order_ok = 1'b1;
        start_i = inject;
        x_i = inject ? ~x : x;
        while (!done_o && cyc < 20) begin
            if (coef_req_o) begin
                if (coef_idx_o != 2'(2 - nreq) || cyc != 2 + 2 * nreq) order_ok = 1'b0;
                nreq++;
            end
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        chk(order_ok && nreq == 3, "R3 coefficient request order", 128'(nreq), 128'd3);
        chk(cyc == 7, "R7 start-to-done latency", 128'(cyc), 128'd7);
        chk(result_o == exp, "R4/R5/R6/R7 result value", 128'(result_o), 128'(exp));
        if (inject) begin
            start_i = 1'b1;
            x_i = ~x;
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o && !done_o, "R9 idle after completion", 128'({busy_o, done_o}), 128'd0);
        if (inject)
            chk(result_o == exp && !coef_req_o, "R8 start ignored while busy",
                128'(result_o), 128'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        cur_a3 = '0; cur_a2 = '0; cur_a1 = '0; cur_a0 = '0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !coef_req_o && result_o == '0, "R1 state in reset",
            128'({busy_o, done_o, coef_req_o}), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && result_o == '0, "R1 state after release",
            128'(result_o), 128'd0);

        // R2: busy from the cycle after start
        cur_a3 = '0;
        start_i = 1'b1; x_i = 18'h1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R2 busy after accepted start", 128'(busy_o), 128'd1);
        while (busy_o) @(negedge clk);

        // table walk: R2..R7 and R10 (junk on coef_i outside requests)
        for (int i = 0; i < NV; i++)
            run(TX[i], TA3[i], TA2[i], TA1[i], TA0[i],
                model(TX[i], TA3[i], TA2[i], TA1[i], TA0[i]), 1'b0);

        // R4: floor truncation, hand values
        run(18'h00001, 67'sd0, 67'sd0, 67'sd1, 67'sd0, 35'h000000000, 1'b0);
        run(18'h00001, 67'sd0, 67'sd0, -67'sd1, 67'sd0, 35'h7FFFFFFFF, 1'b0);
        // R5: zero argument leaves only aligned constant term
        run(18'h00000, 67'sd12345, 67'sd6, 67'sd7, -67'sd1, 35'h7FFFFFFFC, 1'b0);
        // R6: constant term wraps at 35 bits (2^33 * 4 = 2^35 -> 0)
        run(18'h00000, 67'sd0, 67'sd0, 67'sd0, 67'sd8589934592, 35'h000000000, 1'b0);
        // R8: start pulses during busy and in the completion cycle
        run(TX[5], TA3[5], TA2[5], TA1[5], TA0[5],
            model(TX[5], TA3[5], TA2[5], TA1[5], TA0[5]), 1'b1);
        run(TX[0], TA3[0], TA2[0], TA1[0], TA0[0],
            model(TX[0], TA3[0], TA2[0], TA1[0], TA0[0]), 1'b1);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule